// File: doc/BRIEF.md
# SD Block Data Buffer Sequencer

This block is the data path of an SD host controller. It sits between a 32-bit processor data port and a byte-wide card data interface. Between them is a circular word buffer, 256 entries deep by default. A block-configuration word sets the length of each block and the number of blocks. A command word starts a transfer, sets its direction and chooses the hand-off style. In programmed I/O mode the processor is given buffer-ready flags. In DMA mode it is given DMA request lines instead.

On a read, card bytes are packed into words least significant byte first. The card is held off once a whole block is in the buffer, and the processor drains that block. On a write, the processor fills one block's worth of words, and those words are sent to the card one byte at a time, lowest byte first. The block also counts bytes within each block and, when counting is enabled, counts blocks. At the end of a transfer it emits a one-cycle completion pulse and, if requested, an automatic stop command word. A stop command written while a transfer is in progress aborts the transfer and flushes the buffer.

Top module: `sdq_data_seq`

## Requirements
- R1: After reset, every flag, request and pulse output is low. `crd_rx_ready` and `crd_tx_valid` are also low.
- R2: A write to `blk_wdata` sets the block length from bits 10:0 (1 to 1024 bytes) and the block count from bits 31:16. A command word with bit 21 set starts a transfer. When bit 4 is also set, `crd_rx_ready` goes high and card bytes are accepted until the block is full.
- R3: Card bytes are packed into words lowest byte first: the first byte of each word lands in bits 7:0. When the block length is not a multiple of four, the last word of the block is padded with zero bytes.
- R4: In a read, `crd_rx_ready` falls and `rd_buf_ok` rises in the cycle after the last byte of a block is accepted. `rd_buf_ok` stays high until the last buffered word has been read. After that, the next block, if any, is accepted.
- R5: When command bit 0 is set (DMA), the flags are replaced: `rd_dma_req` is raised instead of `rd_buf_ok`, and `wr_dma_req` instead of `wr_buf_ok`. The programmed I/O flags stay low throughout.
- R6: Outside DMA mode, a data-port read while `rd_buf_ok` is low, or a data-port write while `wr_buf_ok` is low, gives a one-cycle `bad_access` pulse and leaves the buffer contents unchanged.
- R7: Command bit 1 enables block counting and bit 5 selects multi-block mode. Each block decrements the count when counting is enabled. The transfer ends after one block when bit 5 is clear, or when the count reaches zero, and `xfer_busy` falls. The count is then reloaded from the configured value.
- R8: When counting is enabled and the remaining count is zero, no data moves: `crd_rx_ready`, `crd_tx_valid` and `wr_buf_ok` stay low.
- R9: In a write (bit 4 clear), `wr_buf_ok` stays high until the current block's word count, ceil(length/4), has been written. The buffered words are sent on `crd_tx_byte` lowest byte first, for exactly the block length in bytes.
- R10: `done_pulse` fires once per transfer. For a read it fires in the cycle after the last word is read; for a write it fires in the cycle after the last byte is sent. When command bit 2 is set, `stop_valid` pulses in the same cycle with `stop_word` equal to 0x0CC30000.
- R11: A command word with index 12 in bits 29:24, written while a transfer is active, ends the transfer, empties the buffer and pulses `done_pulse` without `stop_valid`.
- R12: A data-port read while the buffer is empty returns 0 and gives a one-cycle `buf_err` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_we | input | 1 | Block-configuration write strobe |
| blk_wdata | input | 32 | Length in bits 10:0, count in bits 31:16 |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 32 | Command word |
| dat_wr | input | 1 | Processor data write strobe |
| dat_wdata | input | 32 | Processor write word |
| dat_rd | input | 1 | Processor data read strobe |
| dat_rdata | output | 32 | Word at the buffer head, 0 if empty |
| crd_rx_valid | input | 1 | Card byte available |
| crd_rx_byte | input | 8 | Card byte in |
| crd_rx_ready | output | 1 | Sequencer accepts a card byte |
| crd_tx_valid | output | 1 | Byte for the card available |
| crd_tx_byte | output | 8 | Byte out to the card |
| crd_tx_ready | input | 1 | Card accepts a byte |
| xfer_busy | output | 1 | Transfer in progress |
| rd_buf_ok | output | 1 | Programmed I/O read block ready |
| wr_buf_ok | output | 1 | Programmed I/O write space open |
| rd_dma_req | output | 1 | DMA read request |
| wr_dma_req | output | 1 | DMA write request |
| done_pulse | output | 1 | Transfer complete pulse |
| stop_valid | output | 1 | Automatic stop command pulse |
| stop_word | output | 32 | Stop command word |
| bad_access | output | 1 | Data-port access without permission |
| buf_err | output | 1 | Read from an empty buffer |

## Verification
A six-byte single-block read checks both a full word and a zero-padded partial word, which separates lane ordering faults from padding faults. A two-block DMA read with counting enabled shows whether the card stalls between blocks, whether the count decrements and later reloads, and whether the automatic stop is issued. A five-byte write, with the card held back while the words are loaded, separates the write-window limit from the byte order on the card side. Zero-count starts, accesses without permission in the middle of a block, and an abort cover the paths where nothing must move.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  localparam int LEN_W     = 11;
  localparam int CNT_W     = 16;
  localparam int CNT_LO    = 16;
  localparam int BIT_DMA   = 0;
  localparam int BIT_BCNT  = 1;
  localparam int BIT_AUTO  = 2;
  localparam int BIT_RD    = 4;
  localparam int BIT_MULTI = 5;
  localparam int BIT_DATA  = 21;
  localparam int IDX_LO    = 24;
  localparam logic [5:0]  STOP_IDX  = 6'd12;
  localparam logic [31:0] STOP_WORD = 32'h0CC3_0000;

  // words needed to hold one block of len bytes
  function automatic logic [11:0] words_for_len(input logic [LEN_W-1:0] len);
    return ({1'b0, len} + 12'd3) >> 2;
  endfunction

  // place a byte into its lane of a partly built word
  function automatic logic [31:0] merge_byte(input logic [31:0] acc,
                                             input logic [7:0] b,
                                             input logic [1:0] lane);
    return acc | ({24'd0, b} << {lane, 3'b000});
  endfunction

  function automatic logic [7:0] pick_byte(input logic [31:0] w,
                                           input logic [1:0] lane);
    return w[{lane, 3'b000} +: 8];
  endfunction
endpackage

// File: rtl/sdq_ring.sv
module sdq_ring #(
  parameter int DEPTH = 256,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full,
  output logic [AW:0]  level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (level == '0);
  assign full    = (level == (AW+1)'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      level <= level + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/sdq_count.sv
module sdq_count
  import sdq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_both,
  input  logic             ld_len,
  input  logic [LEN_W-1:0] len_src,
  input  logic [CNT_W-1:0] cnt_src,
  input  logic             step,
  input  logic             count_en,
  input  logic             multi,
  output logic [LEN_W-1:0] byte_left,
  output logic [CNT_W-1:0] blk_left,
  output logic             blk_end,
  output logic             xfer_last,
  output logic             runnable
);
  logic [CNT_W-1:0] blk_next;

  assign blk_end   = step & (byte_left == LEN_W'(1));
  assign blk_next  = count_en ? blk_left - 1'b1 : blk_left;
  assign xfer_last = blk_end & (~multi | (blk_next == '0));
  assign runnable  = ~(count_en & (blk_left == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_left <= '0;
      blk_left  <= '0;
    end else if (ld_both) begin
      byte_left <= len_src;
      blk_left  <= cnt_src;
    end else if (ld_len) begin
      byte_left <= len_src;
    end else if (blk_end) begin
      byte_left <= len_src;
      blk_left  <= xfer_last ? cnt_src : blk_next;
    end else if (step) begin
      byte_left <= byte_left - 1'b1;
    end
  end
endmodule

// File: rtl/sdq_lane.sv
module sdq_lane
  import sdq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        step,
  input  logic        blk_last,
  input  logic [7:0]  in_byte,
  output logic [1:0]  lane,
  output logic [31:0] word_out,
  output logic        word_done
);
  logic [31:0] acc;

  assign word_out  = merge_byte(acc, in_byte, lane);
  assign word_done = step & ((lane == 2'd3) | blk_last);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      lane <= '0;
      acc  <= '0;
    end else if (step) begin
      if (word_done) begin
        lane <= '0;
        acc  <= '0;
      end else begin
        lane <= lane + 1'b1;
        acc  <= word_out;
      end
    end
  end
endmodule

// File: rtl/sdq_data_seq.sv
module sdq_data_seq
  import sdq_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        blk_we,
  input  logic [31:0] blk_wdata,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  input  logic        dat_wr,
  input  logic [31:0] dat_wdata,
  input  logic        dat_rd,
  output logic [31:0] dat_rdata,
  input  logic        crd_rx_valid,
  input  logic [7:0]  crd_rx_byte,
  output logic        crd_rx_ready,
  output logic        crd_tx_valid,
  output logic [7:0]  crd_tx_byte,
  input  logic        crd_tx_ready,
  output logic        xfer_busy,
  output logic        rd_buf_ok,
  output logic        wr_buf_ok,
  output logic        rd_dma_req,
  output logic        wr_dma_req,
  output logic        done_pulse,
  output logic        stop_valid,
  output logic [31:0] stop_word,
  output logic        bad_access,
  output logic        buf_err
);
  logic [LEN_W-1:0] blk_len_q;
  logic [CNT_W-1:0] blk_cnt_q;
  logic m_dma, m_cnt, m_auto, m_rd, m_multi;
  logic active, held, end_pend;
  logic [11:0] words_acc;
  logic done_q, stop_q, bad_q, err_q;

  // named internal events
  logic [5:0]  cmd_idx;
  logic        abort_req, start_req;
  logic        rx_fire, tx_fire, step, blk_end, xfer_last, runnable;
  logic        wr_window, cpu_push, rd_pop, drain_done, done_evt;
  logic [LEN_W-1:0] byte_left, len_src;
  logic [CNT_W-1:0] blk_left, cnt_src;
  logic [1:0]  lane;
  logic [31:0] packed_word, head;
  logic        word_done, push, pop, empty, full;
  logic [AW:0] level;

  assign cmd_idx   = cmd_wdata[IDX_LO +: 6];
  assign abort_req = cmd_we & (active | held) & (cmd_idx == STOP_IDX);
  assign start_req = cmd_we & ~abort_req & cmd_wdata[BIT_DATA];

  assign len_src = blk_we ? blk_wdata[LEN_W-1:0] : blk_len_q;
  assign cnt_src = blk_we ? blk_wdata[CNT_LO +: CNT_W] : blk_cnt_q;

  assign crd_rx_ready = active & m_rd & ~held & runnable & ~full;
  assign crd_tx_valid = active & ~m_rd & runnable & ~empty;
  assign crd_tx_byte  = pick_byte(head, lane);
  assign rx_fire      = crd_rx_ready & crd_rx_valid;
  assign tx_fire      = crd_tx_valid & crd_tx_ready;
  assign step         = rx_fire | tx_fire;

  assign wr_window  = active & ~m_rd & runnable & (words_acc < words_for_len(blk_len_q));
  assign cpu_push   = dat_wr & wr_window & ~full;
  assign push       = (rx_fire & word_done) | cpu_push;
  assign rd_pop     = dat_rd & held & ~empty;
  assign pop        = rd_pop | (tx_fire & word_done);
  assign drain_done = rd_pop & (level == (AW+1)'(1));
  assign done_evt   = abort_req | (drain_done & end_pend) | (tx_fire & xfer_last);

  sdq_ring #(.DEPTH(DEPTH), .W(32)) ring_i (
    .clk(clk), .rst_n(rst_n), .flush(start_req | abort_req),
    .push(push), .wdata(m_rd ? packed_word : dat_wdata),
    .pop(pop), .rdata(head), .empty(empty), .full(full), .level(level)
  );

  sdq_count cnt_i (
    .clk(clk), .rst_n(rst_n), .ld_both(blk_we), .ld_len(start_req),
    .len_src(len_src), .cnt_src(cnt_src), .step(step),
    .count_en(m_cnt), .multi(m_multi), .byte_left(byte_left),
    .blk_left(blk_left), .blk_end(blk_end), .xfer_last(xfer_last),
    .runnable(runnable)
  );

  sdq_lane lane_i (
    .clk(clk), .rst_n(rst_n), .clear(start_req | abort_req), .step(step),
    .blk_last(byte_left == LEN_W'(1)), .in_byte(crd_rx_byte),
    .lane(lane), .word_out(packed_word), .word_done(word_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_len_q <= '0;
      blk_cnt_q <= '0;
    end else if (blk_we) begin
      blk_len_q <= blk_wdata[LEN_W-1:0];
      blk_cnt_q <= blk_wdata[CNT_LO +: CNT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {m_dma, m_cnt, m_auto, m_rd, m_multi} <= '0;
      active    <= 1'b0;
      held      <= 1'b0;
      end_pend  <= 1'b0;
      words_acc <= '0;
    end else if (start_req) begin
      m_dma     <= cmd_wdata[BIT_DMA];
      m_cnt     <= cmd_wdata[BIT_BCNT];
      m_auto    <= cmd_wdata[BIT_AUTO];
      m_rd      <= cmd_wdata[BIT_RD];
      m_multi   <= cmd_wdata[BIT_MULTI];
      active    <= 1'b1;
      held      <= 1'b0;
      end_pend  <= 1'b0;
      words_acc <= '0;
    end else if (abort_req) begin
      active    <= 1'b0;
      held      <= 1'b0;
      end_pend  <= 1'b0;
      words_acc <= '0;
    end else begin
      if (rx_fire && blk_end) begin
        held <= 1'b1;
        if (xfer_last) begin
          active   <= 1'b0;
          end_pend <= 1'b1;
        end
      end
      if (tx_fire && blk_end) begin
        words_acc <= '0;
        if (xfer_last) active <= 1'b0;
      end else if (cpu_push) begin
        words_acc <= words_acc + 1'b1;
      end
      if (drain_done) begin
        held     <= 1'b0;
        end_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      stop_q <= 1'b0;
      bad_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_evt;
      stop_q <= done_evt & ~abort_req & m_auto;
      bad_q  <= ~m_dma & ((dat_rd & ~held) | (dat_wr & ~wr_window));
      err_q  <= (dat_rd & empty) | (dat_wr & full);
    end
  end

  assign dat_rdata  = empty ? '0 : head;
  assign xfer_busy  = active;
  assign rd_buf_ok  = held & ~m_dma;
  assign rd_dma_req = held & m_dma;
  assign wr_buf_ok  = wr_window & ~m_dma;
  assign wr_dma_req = wr_window & m_dma;
  assign done_pulse = done_q;
  assign stop_valid = stop_q;
  assign stop_word  = STOP_WORD;
  assign bad_access = bad_q;
  assign buf_err    = err_q;
endmodule

// File: rtl/sdq_data_seq_chk.sv
module sdq_data_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_we,
  input logic [31:0] cmd_wdata,
  input logic        crd_rx_valid,
  input logic        crd_rx_ready,
  input logic        crd_tx_valid,
  input logic        xfer_busy,
  input logic        rd_buf_ok,
  input logic        wr_buf_ok,
  input logic        rd_dma_req,
  input logic        wr_dma_req,
  input logic        done_pulse,
  input logic        stop_valid
);
  a_r4_stall_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_buf_ok || rd_dma_req) |-> !crd_rx_ready);

  a_r4_ready_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_buf_ok || rd_dma_req) |-> $past(crd_rx_valid && crd_rx_ready));

  a_r5_rd_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_buf_ok && rd_dma_req));

  a_r5_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_buf_ok && wr_dma_req));

  a_r9_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(crd_rx_ready && crd_tx_valid));

  a_r10_stop_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    stop_valid |-> done_pulse);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (!xfer_busy || $past(cmd_we)));

  a_r11_abort_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_wdata[29:24] == 6'd12 && xfer_busy) |=> !stop_valid);
endmodule

bind sdq_data_seq sdq_data_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
  .crd_rx_valid(crd_rx_valid), .crd_rx_ready(crd_rx_ready),
  .crd_tx_valid(crd_tx_valid), .xfer_busy(xfer_busy),
  .rd_buf_ok(rd_buf_ok), .wr_buf_ok(wr_buf_ok),
  .rd_dma_req(rd_dma_req), .wr_dma_req(wr_dma_req),
  .done_pulse(done_pulse), .stop_valid(stop_valid)
);

// File: tb/sdq_data_seq_tb_top.sv
module sdq_data_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_we = 0, cmd_we = 0, dat_wr = 0, dat_rd = 0;
  logic [31:0] blk_wdata = 0, cmd_wdata = 0, dat_wdata = 0;
  logic crd_rx_valid = 0, crd_tx_ready = 0;
  logic [7:0] crd_rx_byte = 0;
  logic [31:0] dat_rdata, stop_word;
  logic crd_rx_ready, crd_tx_valid;
  logic [7:0] crd_tx_byte;
  logic xfer_busy, rd_buf_ok, wr_buf_ok, rd_dma_req, wr_dma_req;
  logic done_pulse, stop_valid, bad_access, buf_err;
  int n_checks = 0, n_errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sdq_data_seq dut_i (.*);

  localparam logic [31:0] C_RD1    = 32'h1120_0010;
  localparam logic [31:0] C_RDMDMA = 32'h1220_0037;
  localparam logic [31:0] C_RDCNT  = 32'h1220_0012;
  localparam logic [31:0] C_WRCNT  = 32'h1920_0002;
  localparam logic [31:0] C_WRAUTO = 32'h1820_0004;
  localparam logic [31:0] C_WRDMA  = 32'h1820_0001;
  localparam logic [31:0] C_ABORT  = 32'h0C00_0000;

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_blk(input int len, input int cnt);
    blk_we = 1; blk_wdata = {16'(cnt), 5'd0, 11'(len)};
    tick(); blk_we = 0;
  endtask

  task automatic set_cmd(input logic [31:0] w);
    cmd_we = 1; cmd_wdata = w;
    tick(); cmd_we = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    crd_rx_valid = 1; crd_rx_byte = b; #1;
    chk(crd_rx_ready == 1, "R2 rx_ready while filling", 32'(crd_rx_ready), 1);
    tick(); crd_rx_valid = 0;
  endtask

  task automatic cpu_read(output logic [31:0] d, output logic bad, output logic err);
    dat_rd = 1; #1 d = dat_rdata;
    tick(); dat_rd = 0;
    bad = bad_access; err = buf_err;
  endtask

  task automatic cpu_write(input logic [31:0] d, output logic bad);
    dat_wr = 1; dat_wdata = d;
    tick(); dat_wr = 0;
    bad = bad_access;
  endtask

  task automatic t_reset();
    chk({crd_rx_ready, crd_tx_valid, xfer_busy, rd_buf_ok, wr_buf_ok, rd_dma_req,
         wr_dma_req, done_pulse, stop_valid, bad_access, buf_err} == 0,
        "R1 reset outputs low",
        32'({crd_rx_ready, crd_tx_valid, xfer_busy, rd_buf_ok, wr_buf_ok, rd_dma_req,
             wr_dma_req, done_pulse, stop_valid, bad_access, buf_err}), 0);
  endtask

  task automatic t_read_pio();
    logic [31:0] d; logic bad, err;
    set_blk(6, 1); set_cmd(C_RD1);
    for (int i = 0; i < 6; i++) send_byte(8'h11 + 8'(i));
    #1;
    chk(crd_rx_ready == 0, "R4 card stalled when block held", 32'(crd_rx_ready), 0);
    chk(rd_buf_ok == 1, "R4 rd_buf_ok after block", 32'(rd_buf_ok), 1);
    chk(xfer_busy == 0, "R7 single block ends transfer", 32'(xfer_busy), 0);
    cpu_read(d, bad, err);
    chk(d == 32'h1413_1211, "R3 little-endian packing", d, 32'h1413_1211);
    chk(rd_buf_ok == 1 && done_pulse == 0, "R4 flag held until drained",
        32'({rd_buf_ok, done_pulse}), 32'b10);
    cpu_read(d, bad, err);
    chk(d == 32'h0000_1615, "R3 partial word zero padded", d, 32'h0000_1615);
    chk(done_pulse == 1 && stop_valid == 0, "R10 done on last read, no stop",
        32'({done_pulse, stop_valid}), 32'b10);
    chk(rd_buf_ok == 0, "R4 flag clears after drain", 32'(rd_buf_ok), 0);
  endtask

  task automatic t_read_dma_multi();
    logic [31:0] d; logic bad, err;
    set_blk(4, 2); set_cmd(C_RDMDMA);
    for (int i = 0; i < 4; i++) send_byte(8'hA0 + 8'(i));
    #1;
    chk(rd_dma_req == 1 && rd_buf_ok == 0, "R5 dma request instead of flag",
        32'({rd_dma_req, rd_buf_ok}), 32'b10);
    chk(xfer_busy == 1, "R7 count 2 keeps transfer going", 32'(xfer_busy), 1);
    cpu_read(d, bad, err);
    chk(d == 32'hA3A2_A1A0, "R3 dma word packing", d, 32'hA3A2_A1A0);
    chk(rd_dma_req == 0 && crd_rx_ready == 1 && done_pulse == 0,
        "R4 next block resumes", 32'({rd_dma_req, crd_rx_ready, done_pulse}), 32'b010);
    for (int i = 0; i < 4; i++) send_byte(8'hB0 + 8'(i));
    #1;
    chk(xfer_busy == 0, "R7 count reached zero", 32'(xfer_busy), 0);
    cpu_read(d, bad, err);
    chk(d == 32'hB3B2_B1B0, "R3 second block word", d, 32'hB3B2_B1B0);
    chk(done_pulse == 1 && stop_valid == 1 && stop_word == 32'h0CC3_0000,
        "R10 auto stop with done", stop_word, 32'h0CC3_0000);
    set_cmd(C_RDMDMA); #1;
    chk(crd_rx_ready == 1, "R7 count reloaded after transfer", 32'(crd_rx_ready), 1);
    set_cmd(C_ABORT);
    chk(done_pulse == 1 && stop_valid == 0, "R11 abort done without stop",
        32'({done_pulse, stop_valid}), 32'b10);
    chk(xfer_busy == 0 && crd_rx_ready == 0, "R11 abort clears transfer",
        32'({xfer_busy, crd_rx_ready}), 0);
  endtask

  task automatic t_zero_count();
    set_blk(4, 0); set_cmd(C_RDCNT); #1;
    chk(xfer_busy == 1 && crd_rx_ready == 0, "R8 read stalls at zero count",
        32'({xfer_busy, crd_rx_ready}), 32'b10);
    set_cmd(C_ABORT);
    set_cmd(C_WRCNT); #1;
    chk(wr_buf_ok == 0 && crd_tx_valid == 0, "R8 write stalls at zero count",
        32'({wr_buf_ok, crd_tx_valid}), 0);
    set_cmd(C_ABORT);
  endtask

  task automatic t_bad_access();
    logic [31:0] d; logic bad, err;
    cpu_read(d, bad, err);
    chk(bad == 1, "R6 idle read is bad access", 32'(bad), 1);
    chk(err == 1 && d == 0, "R12 empty read returns zero with error", d, 0);
    cpu_write(32'hDEAD_BEEF, bad);
    chk(bad == 1, "R6 idle write is bad access", 32'(bad), 1);
    set_blk(8, 1); set_cmd(C_RD1);
    for (int i = 0; i < 4; i++) send_byte(8'h50 + 8'(i));
    cpu_read(d, bad, err);
    chk(bad == 1 && err == 0, "R6 mid-block read is bad access",
        32'({bad, err}), 32'b10);
    for (int i = 4; i < 8; i++) send_byte(8'h50 + 8'(i));
    cpu_read(d, bad, err);
    chk(d == 32'h5352_5150 && bad == 0, "R6 buffer untouched by bad read",
        d, 32'h5352_5150);
    cpu_read(d, bad, err);
    chk(d == 32'h5756_5554 && done_pulse == 1, "R10 done after 8-byte block",
        d, 32'h5756_5554);
  endtask

  task automatic t_write_pio();
    logic bad; logic [7:0] exp_b [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'hEE};
    set_blk(5, 1); set_cmd(C_WRAUTO); #1;
    chk(wr_buf_ok == 1, "R9 write window open", 32'(wr_buf_ok), 1);
    cpu_write(32'h4433_2211, bad);
    chk(wr_buf_ok == 1 && bad == 0, "R9 window open after first word",
        32'({wr_buf_ok, bad}), 32'b10);
    cpu_write(32'h0000_00EE, bad); #1;
    chk(wr_buf_ok == 0, "R9 window closed after block words", 32'(wr_buf_ok), 0);
    cpu_write(32'h9999_9999, bad);
    chk(bad == 1, "R6 write past window is bad access", 32'(bad), 1);
    crd_tx_ready = 1;
    for (int i = 0; i < 5; i++) begin
      #1;
      chk(crd_tx_valid == 1 && crd_tx_byte == exp_b[i], "R9 byte order to card",
          32'(crd_tx_byte), 32'(exp_b[i]));
      tick();
    end
    crd_tx_ready = 0;
    chk(done_pulse == 1 && stop_valid == 1, "R10 write done with auto stop",
        32'({done_pulse, stop_valid}), 32'b11);
    chk(xfer_busy == 0 && crd_tx_valid == 0, "R9 exactly block length sent",
        32'({xfer_busy, crd_tx_valid}), 0);
  endtask

  task automatic t_write_dma();
    logic bad;
    set_blk(4, 1); set_cmd(C_WRDMA); #1;
    chk(wr_dma_req == 1 && wr_buf_ok == 0, "R5 write dma request",
        32'({wr_dma_req, wr_buf_ok}), 32'b10);
    cpu_write(32'h0807_0605, bad);
    chk(wr_dma_req == 0 && bad == 0, "R5 dma request drops after block",
        32'({wr_dma_req, bad}), 0);
    crd_tx_ready = 1;
    for (int i = 0; i < 4; i++) tick();
    crd_tx_ready = 0;
    chk(done_pulse == 1 && stop_valid == 0, "R10 dma write done, no auto stop",
        32'({done_pulse, stop_valid}), 32'b10);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 t_reset();
    rst_n = 1; tick();
    t_reset();
    t_read_pio();
    t_read_dma_multi();
    t_zero_count();
    t_bad_access();
    t_write_pio();
    t_write_dma();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule